// File: doc/BRIEF.md
# Always-On Interval Timer with Clock Prescaling

This block is a 32-bit up-counting interval timer meant for an always-on power domain. It picks its tick source from two oscillator strobes or a peripheral-clock strobe. The chosen strobe passes through an optional first divide stage and then a programmable prescaler, and the result advances the counter. Software starts and stops counting with a run bit. It sets a terminal value, and when the count arrives there the block latches a sticky status flag and emits a one-cycle match event toward an interrupt controller.

Everything runs on one system clock. The three tick sources arrive as single-cycle enable strobes synchronous to that clock, and both divide stages are enable counters, so no derived clock exists inside the block. Software clears a match by writing a one to a self-clearing reset bit in the command register. That write zeroes the count, drops the status flag and restarts both divide stages from phase zero.

The register port is a simple write strobe with a byte offset and a 32-bit data word, plus an independent read offset with a combinational read-data return.

Top module: `aon_timer`

## Requirements
- R1: After reset every readable register (offsets 0x00, 0x04, 0x6C, 0x70, 0x74, 0x78, 0x7C) returns zero and the match event is low.
- R2: Control bit 0 (offset 0x00) chooses the oscillator strobe: 0 takes osc0_tick, 1 takes osc1_tick.
- R3: Control bit 25 chooses the tick source: 0 takes the chosen oscillator strobe, 1 takes pclk_tick.
- R4: Control bit 24 enables the first divide stage, whose ratio is control bits 23:20 plus one. With bit 24 clear, bits 23:20 have no effect on the rate.
- R5: The counter advances by exactly one per N first-stage ticks, where N is the value at offset 0x74. A value of 0 behaves as 1.
- R6: Command bit 0 (offset 0x6C) is the run bit. Writing 1 starts counting and writing 0 stops it. A stopped count holds, and bit 0 reads back the run state.
- R7: Writing 1 to command bit 1 zeroes the count (offset 0x78) and the status flag by the next cycle. That bit always reads 0. If run and reset are written together, the count is still zero after that write.
- R8: While running, a count equal to the end value (offset 0x70) sets status bit 0 at offset 0x7C and its mirror at bit 0 of offset 0x04. Both stay set until a reset command, including after a stop.
- R9: After reaching the end value the count holds there while running.
- R10: match_evt is high for exactly one cycle per match, in the cycle before the status flag sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc0_tick | input | 1 | Enable strobe from the first oscillator |
| osc1_tick | input | 1 | Enable strobe from the second oscillator |
| pclk_tick | input | 1 | Enable strobe from the peripheral clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Byte offset of the read |
| rd_data | output | 32 | Read data for rd_addr |
| match_evt | output | 1 | One-cycle match event for the interrupt controller |

## Verification
The bench measures exact increment counts over known windows. This catches an off-by-one in either divide stage or a zero prescaler value that stalls or wraps, because the count would come out wrong. It holds the count at the end value long after a match and looks for a single event pulse. A design that kept counting past the terminal value, or repeated the event, would fail here. It writes run and reset together mid-count and checks for a zero count right after, which a design letting the run path win would miss. It also selects sources whose strobes are idle. A crossed source mux would count when it should not.

// File: rtl/aon_timer.sv
module aon_timer #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int FDIV_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc0_tick,
  input  logic              osc1_tick,
  input  logic              pclk_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              match_evt
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_MIRR = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'('h6C);
  localparam logic [ADDR_W-1:0] A_END  = ADDR_W'('h70);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'('h74);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'('h78);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h7C);
  localparam int SRC_BIT  = 25;
  localparam int FEN_BIT  = 24;
  localparam int FDIV_LSB = 20;

  logic              osc_sel_q, src_sel_q, fen_q, run_q, stat_q;
  logic [FDIV_W-1:0] fdiv_q, fcnt_q;
  logic [CNT_W-1:0]  end_q, div_q, pcnt_q, cnt_q, lim;
  logic              src_tick, pre_tick, cnt_tick, at_end;

  wire ctrl_wr = wr_en && (wr_addr == A_CTRL);
  wire cmd_wr  = wr_en && (wr_addr == A_CMD);
  wire end_wr  = wr_en && (wr_addr == A_END);
  wire div_wr  = wr_en && (wr_addr == A_DIV);
  wire rst_cmd = cmd_wr && wr_data[1];

  assign src_tick  = src_sel_q ? pclk_tick : (osc_sel_q ? osc1_tick : osc0_tick);
  assign pre_tick  = fen_q ? (src_tick && (fcnt_q >= fdiv_q)) : src_tick;
  assign lim       = (div_q == '0) ? '0 : div_q - CNT_W'(1);
  assign cnt_tick  = pre_tick && (pcnt_q >= lim);
  assign at_end    = (cnt_q == end_q);
  assign match_evt = run_q && at_end && !stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_sel_q <= 1'b0;
      src_sel_q <= 1'b0;
      fen_q     <= 1'b0;
      fdiv_q    <= '0;
    end else if (ctrl_wr) begin
      osc_sel_q <= wr_data[0];
      src_sel_q <= wr_data[SRC_BIT];
      fen_q     <= wr_data[FEN_BIT];
      fdiv_q    <= wr_data[FDIV_LSB +: FDIV_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_q <= '0;
      div_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (end_wr) end_q <= wr_data[CNT_W-1:0];
      if (div_wr) div_q <= wr_data[CNT_W-1:0];
      if (cmd_wr) run_q <= wr_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                fcnt_q <= '0;
    else if (rst_cmd || !fen_q) fcnt_q <= '0;
    else if (src_tick)          fcnt_q <= (fcnt_q >= fdiv_q) ? '0 : fcnt_q + FDIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pcnt_q <= '0;
    else if (rst_cmd)           pcnt_q <= '0;
    else if (run_q && pre_tick) pcnt_q <= cnt_tick ? '0 : pcnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      stat_q <= 1'b0;
    end else if (rst_cmd) begin
      cnt_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      if (run_q && cnt_tick && !at_end) cnt_q <= cnt_q + CNT_W'(1);
      if (run_q && at_end) stat_q <= 1'b1;
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_CTRL: begin
        rd_data[0]                   = osc_sel_q;
        rd_data[SRC_BIT]             = src_sel_q;
        rd_data[FEN_BIT]             = fen_q;
        rd_data[FDIV_LSB +: FDIV_W]  = fdiv_q;
      end
      A_MIRR:  rd_data[0] = stat_q;
      A_CMD:   rd_data[0] = run_q;
      A_END:   rd_data[CNT_W-1:0] = end_q;
      A_DIV:   rd_data[CNT_W-1:0] = div_q;
      A_CNT:   rd_data[CNT_W-1:0] = cnt_q;
      A_STAT:  rd_data[0] = stat_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/aon_timer_chk.sv
module aon_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_cmd,
  input logic             run_q,
  input logic             stat_q,
  input logic             match_evt,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] end_q
);
  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q && !rst_cmd |=> stat_q); // R8
  AST_EVT_SETS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt && !rst_cmd |=> stat_q); // R8
  AST_RST_CMD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd |=> (cnt_q == '0) && !stat_q); // R7
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && !rst_cmd |=> $stable(cnt_q)); // R6
  AST_END_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && (cnt_q == end_q) && !rst_cmd |=> $stable(cnt_q)); // R9
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_cmd |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1))); // R5
  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt && !rst_cmd |=> !match_evt); // R10
endmodule

bind aon_timer aon_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_cmd(rst_cmd), .run_q(run_q), .stat_q(stat_q),
  .match_evt(match_evt), .cnt_q(cnt_q), .end_q(end_q)
);

// File: tb/aon_timer_bench.sv
`timescale 1ns/1ps
module aon_timer_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, osc0_tick, osc1_tick, pclk_tick, wr_en, match_evt;
  logic [7:0] wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;

  aon_timer u_aon_timer (
    .clk(clk), .rst_n(rst_n), .osc0_tick(osc0_tick), .osc1_tick(osc1_tick),
    .pclk_tick(pclk_tick), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .match_evt(match_evt)
  );

  localparam logic [7:0] CTRL = 8'h00, MIRR = 8'h04, CMD = 8'h6C, ENDV = 8'h70,
                         DIVV = 8'h74, CNT = 8'h78, STAT = 8'h7C;

  typedef struct { logic [7:0] a; logic [31:0] e; string tag; } item_t;
  item_t sbq[$];
  int pushed = 0, served = 0, errs = 0, checks = 0, evt_seen = 0;
  bit finished = 0;

  initial begin : monitor
    item_t it;
    rd_addr = 8'h00;
    forever begin
      wait (pushed > served);
      it = sbq.pop_front();
      rd_addr = it.a;
      #1;
      checks++;
      if (rd_data !== it.e) begin
        errs++;
        $display("FAIL %s: offset %h got %h expected %h", it.tag, it.a, rd_data, it.e);
      end
      served++;
    end
  end

  always @(negedge clk) if (rst_n && match_evt) evt_seen++;

  task automatic chk(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.a = a; it.e = e; it.tag = tag;
    sbq.push_back(it);
    pushed++;
    wait (served == pushed);
    @(negedge clk);
  endtask

  task automatic cmp(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic burst(input int k);
    wr(CMD, 32'h3);
    idle(k);
    wr(CMD, 32'h0);
  endtask

  initial begin : watchdog
    #(4 * 200000);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    osc0_tick = 1'b0; osc1_tick = 1'b0; pclk_tick = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    chk(CTRL, 32'h0, "R1 control");
    chk(CNT,  32'h0, "R1 count");
    chk(STAT, 32'h0, "R1 status");
    chk(MIRR, 32'h0, "R1 mirror");
    chk(CMD,  32'h0, "R1 command");
    chk(ENDV, 32'h0, "R1 end");
    chk(DIVV, 32'h0, "R1 divider");
    cmp(match_evt, 0, "R1 event");

    osc1_tick = 1'b1; pclk_tick = 1'b1;
    wr(ENDV, 32'hFFFF_FFFF);
    wr(DIVV, 32'd4);
    wr(CTRL, 32'h0200_0000);
    chk(CTRL, 32'h0200_0000, "R3 control readback");
    burst(39);
    chk(CNT, 32'd10, "R5 divide by 4 over 40 cycles");
    chk(CMD, 32'h0, "R6 run reads 0 after stop");
    idle(10);
    chk(CNT, 32'd10, "R6 stopped count holds");

    wr(DIVV, 32'd0);
    burst(9);
    chk(CNT, 32'd10, "R5 divider 0 acts as 1");

    wr(DIVV, 32'd1);
    wr(CTRL, 32'h02F0_0000);
    burst(9);
    chk(CNT, 32'd10, "R4 field ignored with stage off");

    wr(CTRL, 32'h0320_0000);
    wr(DIVV, 32'd2);
    chk(CTRL, 32'h0320_0000, "R4 control readback");
    burst(35);
    chk(CNT, 32'd6, "R4 ratio 3 times prescale 2");

    wr(DIVV, 32'd1);
    wr(CTRL, 32'h0);
    burst(19);
    chk(CNT, 32'd0, "R2 idle oscillator 0 selected");
    wr(CTRL, 32'h1);
    burst(19);
    chk(CNT, 32'd20, "R2 oscillator 1 selected");

    pclk_tick = 1'b0;
    wr(CTRL, 32'h0200_0001);
    burst(19);
    chk(CNT, 32'd0, "R3 idle peripheral strobe selected");
    pclk_tick = 1'b1;

    wr(CTRL, 32'h0200_0000);
    wr(ENDV, 32'd5);
    evt_seen = 0;
    wr(CMD, 32'h3);
    idle(19);
    chk(CNT, 32'd5, "R9 count holds at end");
    chk(STAT, 32'h1, "R8 status set");
    chk(MIRR, 32'h1, "R8 mirror set");
    cmp(evt_seen, 1, "R10 single event pulse");
    wr(CMD, 32'h0);
    idle(5);
    chk(STAT, 32'h1, "R8 status sticky after stop");

    wr(CMD, 32'h2);
    chk(CNT, 32'd0, "R7 reset zeroes count");
    chk(STAT, 32'h0, "R7 reset clears status");
    chk(MIRR, 32'h0, "R7 reset clears mirror");
    chk(CMD, 32'h0, "R7 reset bit reads 0");

    wr(ENDV, 32'hFFFF_FFFF);
    wr(CMD, 32'h1);
    idle(20);
    wr(CMD, 32'h3);
    chk(CNT, 32'd0, "R7 reset wins over run");
    chk(CMD, 32'h1, "R6 run reads back, R7 reset bit 0");
    wr(CMD, 32'h0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule